// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Idle Frames

This block turns characters into a serial bit stream on one output line. A character is a low start bit, then 7, 8 or 9 data bits with the least significant bit first, then one or two high stop bits. The line rests high whenever nothing is being sent. Software-side logic writes a word into a single-entry holding buffer, and the block moves it into its shift register as soon as the line is free. Writing the next word while the current one is on the line keeps characters back to back.

Timing comes from a baud tick enable input. Each bit lasts a programmable number of ticks. When the enable input rises, the block first sends an idle frame: the line is held high for one full character time, stop bits included. A break request is remembered until the current frame ends. The break frame is then sent ahead of any buffered word: a low period whose length follows the word length, then two high bits. Dropping the enable abandons the character in progress and holds the bit timer where it was.

Top module: `sertx_top`

## Requirements
- R1: While reset is applied and right after it, `tx_out` is 1, `buf_empty` is 1 and `tx_done` is 1.
- R2: The data frame is one low start bit followed by the data bits, least significant first. The number of data bits comes from `word_len`: code 00 gives 8, 01 gives 9, 10 gives 7.
- R3: `stop_sel` code 10 appends two high stop bits and every other code appends one. Every bit lasts exactly `bit_ticks` baud ticks. The line is high again in the first cycle after the last stop bit.
- R4: A write is taken only when `tx_en` is 1 and the buffer is empty, and `buf_empty` is 0 in the cycle after it. A write while the buffer is full is dropped. `buf_empty` returns to 1 in the cycle the start bit appears.
- R5: When `tx_en` rises, an idle frame is sent before any data. The line stays high and `tx_done` is 0 for (1 + data bits + stop bits) bit periods.
- R6: `brk_req` is latched while enabled and acted on after the current frame. The break frame drives the line low for (data bits + 2) bit periods and then high for 2 bit periods. It goes ahead of a buffered word, and it is sent only once per request.
- R7: With `tx_en` at 0, `tx_out` is 1 from the next cycle on. The abandoned character is not resumed, and writes are dropped while disabled.
- R8: The bit timer advances only on cycles with `baud_tick` at 1. With no ticks, the line holds its current bit.
- R9: `tx_done` is 0 while any frame is on the line. It becomes 1 when the last stop bit ends with no word buffered and no break pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable; a rise triggers an idle frame |
| word_len | input | 2 | Data bits: 00 = 8, 01 = 9, 10 = 7 |
| stop_sel | input | 2 | Stop bits: 10 = two, other codes = one |
| bit_ticks | input | TICK_W | Baud ticks per bit (0 is treated as 1) |
| baud_tick | input | 1 | Baud tick enable |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send; bits above the word length are unused |
| brk_req | input | 1 | Break frame request |
| tx_out | output | 1 | Serial line, high when idle |
| buf_empty | output | 1 | Holding buffer can take a word |
| tx_done | output | 1 | No frame in flight and nothing waiting |

## Verification
A shift register loaded with the wrong pattern shows up as a wrong line level within one bit period of the start edge. A bit counter that is off by one changes the frame length, which shows as the line being low, or not yet high, in the cycle right after the expected last stop bit. Wrong priority or a stuck pending flag shows as the wrong frame following the current one: a break after the data instead of before it, or a second break. Idle-frame and disable faults show on `tx_done`, which stays low for a count of cycles other than the expected one, or on a line that fails to return high in the cycle after the enable drops.

// File: rtl/sertx_pkg.sv
// Shared constants, frame kind type and word-length decode for the
// serial transmitter. Assumes at most 9 data bits and 2 stop bits.
package sertx_pkg;
    localparam int DATA_MAX = 9;
    localparam int FRAME_W  = DATA_MAX + 4;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FK_IDLE = 2'd0,
        FK_BRK  = 2'd1,
        FK_DATA = 2'd2
    } frame_kind_e;

    // Decode the word length code into a count of data bits.
    function automatic logic [3:0] wl_bits(input logic [1:0] code);
        case (code)
            2'b01:   return 4'd9;
            2'b10:   return 4'd7;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/sertx_bit_timer.sv
// Counts baud ticks within one bit period and pulses bit_end on the
// tick that closes the period. It holds its count whenever run is low
// and is cleared by clr when a new frame loads. bit_ticks must stay
// stable while a frame is in flight; 0 is treated as 1.
module sertx_bit_timer #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic              tick,
    input  logic [TICK_W-1:0] bit_ticks,
    output logic              bit_end
);
    logic [TICK_W-1:0] cnt;
    logic [TICK_W-1:0] lim_m1;

    // Last count value of a bit period.
    assign lim_m1  = (bit_ticks == '0) ? '0 : bit_ticks - 1'b1;
    assign bit_end = run && tick && (cnt == lim_m1);

    // Advance on ticks while running, wrap at the period end, freeze otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (run && tick) cnt <= bit_end ? '0 : cnt + 1'b1;
    end

    // R8
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/sertx_hold_buf.sv
// Single-entry holding buffer between the write strobe and the shift
// register. The caller gates wr_acc so that a write only lands when empty.
module sertx_hold_buf #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data_q
);
    // Track occupancy: a write fills, a take empties.
    always_ff @(posedge clk) begin
        if (!rst_n)      full <= 1'b0;
        else if (wr_acc) full <= 1'b1;
        else if (take)   full <= 1'b0;
    end

    // Capture the word on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (wr_acc) data_q <= wr_data;
    end

    // R4
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> $stable(data_q));
endmodule

// File: rtl/sertx_frame_pack.sv
// Builds the line pattern (bit 0 goes out first) and the bit count for
// the next frame: data character, idle frame or break frame.
module sertx_frame_pack
    import sertx_pkg::*;
(
    input  frame_kind_e          kind,
    input  logic [DATA_MAX-1:0]  data,
    input  logic [1:0]           word_len,
    input  logic [1:0]           stop_sel,
    output logic [FRAME_W-1:0]   pat,
    output logic [CNT_W-1:0]     nbits
);
    logic [3:0] wl;
    logic [3:0] ns;

    // Compose the pattern and length of the selected frame kind.
    always_comb begin
        wl    = wl_bits(word_len);
        ns    = (stop_sel == 2'b10) ? 4'd2 : 4'd1;
        pat   = '1;
        nbits = CNT_W'(4'd1 + wl + ns);
        case (kind)
            FK_DATA: begin
                pat[0] = 1'b0;
                for (int i = 0; i < DATA_MAX; i++)
                    if (i < int'(wl)) pat[i+1] = data[i];
            end
            FK_BRK: begin
                for (int i = 0; i < FRAME_W; i++)
                    if (i < int'(wl) + 2) pat[i] = 1'b0;
                nbits = CNT_W'(wl + 4'd4);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sertx_top.sv
// Serial character transmitter. It picks the next frame (idle first after
// enable, then break, then buffered data), shifts it out one bit per
// bit period, and reports buffer and completion status. Dropping tx_en
// abandons the frame in flight and freezes the bit timer.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic [1:0]          word_len,
    input  logic [1:0]          stop_sel,
    input  logic [TICK_W-1:0]   bit_ticks,
    input  logic                baud_tick,
    input  logic                wr_valid,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                brk_req,
    output logic                tx_out,
    output logic                buf_empty,
    output logic                tx_done
);
    logic en_q, idle_pend, brk_pend, busy, buf_full, bit_end, frame_end;
    logic can_ld, ld_idle, ld_brk, ld_data, ld_any, wr_acc;
    logic [FRAME_W-1:0]  shreg, pat;
    logic [CNT_W-1:0]    bits_left, nbits;
    logic [DATA_MAX-1:0] buf_q;
    frame_kind_e         cur_kind, ld_kind;

    // Load selection: idle preamble, then break, then buffered data.
    assign can_ld    = tx_en && !busy;
    assign ld_idle   = can_ld && idle_pend;
    assign ld_brk    = can_ld && !idle_pend && brk_pend;
    assign ld_data   = can_ld && !idle_pend && !brk_pend && buf_full;
    assign ld_any    = ld_idle || ld_brk || ld_data;
    assign ld_kind   = ld_idle ? FK_IDLE : (ld_brk ? FK_BRK : FK_DATA);
    assign wr_acc    = wr_valid && tx_en && !buf_full;
    assign frame_end = busy && bit_end && (bits_left == CNT_W'(1));
    assign buf_empty = !buf_full;
    assign tx_out    = busy ? shreg[0] : 1'b1;

    sertx_hold_buf #(.DW(DATA_MAX)) hold_i (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_data(wr_data),
        .take(ld_data), .full(buf_full), .data_q(buf_q)
    );

    sertx_frame_pack pack_i (
        .kind(ld_kind), .data(buf_q), .word_len(word_len),
        .stop_sel(stop_sel), .pat(pat), .nbits(nbits)
    );

    sertx_bit_timer #(.TICK_W(TICK_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(busy && tx_en), .clr(ld_any),
        .tick(baud_tick), .bit_ticks(bit_ticks), .bit_end(bit_end)
    );

    // Remember the enable level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= tx_en;
    end

    // Idle preamble request, raised by an enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)    idle_pend <= 1'b0;
        else if (tx_en && !en_q) idle_pend <= 1'b1;
        else if (ld_idle)        idle_pend <= 1'b0;
    end

    // Break request latch, released when the break frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)                     brk_pend <= 1'b0;
        else if (frame_end && cur_kind == FK_BRK) brk_pend <= 1'b0;
        else if (brk_req)                         brk_pend <= 1'b1;
    end

    // Shift register and bit counter of the frame in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            cur_kind  <= FK_IDLE;
        end else if (!tx_en) begin
            busy <= 1'b0;
        end else if (ld_any) begin
            busy      <= 1'b1;
            shreg     <= pat;
            bits_left <= nbits;
            cur_kind  <= ld_kind;
        end else if (busy && bit_end) begin
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // Completion flag: low while a frame runs, high once nothing waits.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) tx_done <= 1'b1;
        else if (ld_any)      tx_done <= 1'b0;
        else if (frame_end && !buf_full && !idle_pend &&
                 (cur_kind == FK_BRK || !brk_pend))
            tx_done <= 1'b1;
    end

    // R7
    dis_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tx_out);
    // R9
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_done);
    // R4
    buf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && tx_en && buf_empty) |=> !buf_empty);
    // R6
    brk_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (can_ld && brk_pend && !idle_pend) |=> (busy && cur_kind == FK_BRK));
    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && cur_kind != FK_IDLE) |-> !tx_out);
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TW = 8;

    logic          clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, baud_tick = 1'b1;
    logic          wr_valid = 1'b0, brk_req = 1'b0;
    logic [1:0]    word_len = 2'b00, stop_sel = 2'b00;
    logic [TW-1:0] bit_ticks = 8'd1;
    logic [8:0]    wr_data = '0;
    logic          tx_out, buf_empty, tx_done;
    int            n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    sertx_top #(.TICK_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .word_len(word_len),
        .stop_sel(stop_sel), .bit_ticks(bit_ticks), .baud_tick(baud_tick),
        .wr_valid(wr_valid), .wr_data(wr_data), .brk_req(brk_req),
        .tx_out(tx_out), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wl_of(input int c);
        return (c == 1) ? 9 : ((c == 2) ? 7 : 8);
    endfunction

    function automatic logic [12:0] data_pat(input logic [8:0] d, input int wl);
        logic [12:0] p = '1;
        p[0] = 1'b0;
        for (int i = 0; i < wl; i++) p[i+1] = d[i];
        return p;
    endfunction

    function automatic logic [12:0] brk_pat(input int wl);
        logic [12:0] p = '1;
        for (int i = 0; i < wl + 2; i++) p[i] = 1'b0;
        return p;
    endfunction

    // Wait for the start edge, then check every sample of every bit and the
    // first sample after the frame.
    task automatic frame_check(input logic [12:0] pat, input int n, input int bt,
                               input string req);
        int guard = 0;
        while (tx_out !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 5000, {req, " start seen"}, guard, 0);
        for (int i = 0; i < n; i++) begin
            int bad = 0;
            for (int j = 0; j < bt; j++) begin
                if (tx_out !== pat[i]) bad++;
                @(negedge clk);
            end
            chk(bad == 0, $sformatf("%s bit%0d", req, i), bad, 0);
        end
        chk(tx_out === 1'b1, {req, " line high after frame"}, int'(tx_out), 1);
    endtask

    // Count cycles with tx_done low; the line must stay high throughout.
    task automatic idle_check(input int exp_len, input string req);
        int guard = 0, len = 0, low = 0;
        while (tx_done !== 1'b0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        while (tx_done === 1'b0 && len < 5000) begin
            if (tx_out !== 1'b1) low++;
            len++;
            @(negedge clk);
        end
        chk(len == exp_len, {req, " idle length"}, len, exp_len);
        chk(low == 0, {req, " idle line high"}, low, 0);
    endtask

    task automatic write_word(input logic [8:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic quiet_check(input int cycles, input string req);
        int low = 0;
        for (int i = 0; i < cycles; i++) begin
            if (tx_out !== 1'b1) low++;
            @(negedge clk);
        end
        chk(low == 0, {req, " line stays high"}, low, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(tx_out === 1'b1, "R1 tx_out in reset", int'(tx_out), 1);
        chk(buf_empty === 1'b1, "R1 buf_empty in reset", int'(buf_empty), 1);
        chk(tx_done === 1'b1, "R1 tx_done in reset", int'(tx_done), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_out === 1'b1 && buf_empty === 1'b1 && tx_done === 1'b1,
            "R1 state after reset", int'({tx_out, buf_empty, tx_done}), 7);

        // R2 R3 R5 sweep over word length, stop bits and ticks per bit
        for (int wc = 0; wc < 3; wc++) begin
            for (int sc = 0; sc < 2; sc++) begin
                for (int bi = 0; bi < 2; bi++) begin
                    int wl, ns, bt, n;
                    logic [8:0] d;
                    wl = wl_of(wc);
                    ns = sc + 1;
                    bt = (bi == 1) ? 3 : 1;
                    n  = 1 + wl + ns;
                    @(negedge clk);
                    tx_en     = 1'b0;
                    word_len  = 2'(wc);
                    stop_sel  = (sc == 1) ? 2'b10 : 2'b00;
                    bit_ticks = TW'(bt);
                    @(negedge clk);
                    tx_en = 1'b1;
                    idle_check(n * bt, "R5");
                    d = 9'(165 ^ (wc * 37 + sc * 11 + bi * 5));
                    write_word(d);
                    chk(buf_empty === 1'b0, "R4 buffer full after write", int'(buf_empty), 0);
                    frame_check(data_pat(d, wl), n, bt, "R2 R3 frame A");
                    chk(tx_done === 1'b1, "R9 done after frame", int'(tx_done), 1);
                    write_word(~d);
                    frame_check(data_pat(~d, wl), n, bt, "R2 R3 frame B");
                    chk(buf_empty === 1'b1, "R4 buffer empty after load", int'(buf_empty), 1);
                end
            end
        end

        // R4 R9 back-to-back words, third write dropped while buffer full
        @(negedge clk);
        tx_en = 1'b0; word_len = 2'b00; stop_sel = 2'b00; bit_ticks = 8'd2;
        @(negedge clk);
        tx_en = 1'b1;
        idle_check(20, "R5 second enable");
        fork
            begin
                frame_check(data_pat(9'h03C, 8), 10, 2, "R4 first word");
                chk(tx_done === 1'b0, "R9 done low with word waiting", int'(tx_done), 0);
                frame_check(data_pat(9'h0C3, 8), 10, 2, "R4 second word");
                chk(tx_done === 1'b1, "R9 done after last word", int'(tx_done), 1);
            end
            begin
                write_word(9'h03C);
                @(negedge clk);
                write_word(9'h0C3);
                chk(buf_empty === 1'b0, "R4 second word buffered", int'(buf_empty), 0);
                write_word(9'h055);
            end
        join
        quiet_check(40, "R4 dropped write");

        // R6 break goes ahead of buffered data and is sent once
        fork
            begin
                frame_check(data_pat(9'h011, 8), 10, 2, "R6 word before break");
                frame_check(brk_pat(8), 12, 2, "R6 break frame");
                frame_check(data_pat(9'h1EE, 8), 10, 2, "R6 word after break");
                chk(tx_done === 1'b1, "R9 done after break sequence", int'(tx_done), 1);
            end
            begin
                write_word(9'h011);
                @(negedge clk);
                write_word(9'h1EE);
                brk_req = 1'b1;
                @(negedge clk);
                brk_req = 1'b0;
            end
        join
        quiet_check(60, "R6 single break");

        // R6 break length with 9 and 7 data bits
        for (int wc = 1; wc < 3; wc++) begin
            @(negedge clk);
            word_len = 2'(wc);
            brk_req = 1'b1;
            @(negedge clk);
            brk_req = 1'b0;
            frame_check(brk_pat(wl_of(wc)), wl_of(wc) + 4, 2, "R6 break length");
        end
        word_len = 2'b00;

        // R7 disable in mid-character
        begin
            int guard = 0;
            write_word(9'h0F0);
            while (tx_out !== 1'b0 && guard < 100) begin
                @(negedge clk);
                guard++;
            end
            repeat (5) @(negedge clk);
            tx_en = 1'b0;
            @(negedge clk);
            chk(tx_out === 1'b1, "R7 line high after disable", int'(tx_out), 1);
            write_word(9'h00F);
            chk(buf_empty === 1'b1, "R7 write dropped while disabled", int'(buf_empty), 1);
            quiet_check(30, "R7 disabled");
            @(negedge clk);
            tx_en = 1'b1;
            idle_check(20, "R5 R7 re-enable");
            quiet_check(60, "R7 abandoned not resumed");
        end

        // R8 no ticks, no progress
        begin
            int hi = 0;
            baud_tick = 1'b0;
            write_word(9'h0A0);
            @(negedge clk);
            for (int i = 0; i < 12; i++) begin
                if (tx_out !== 1'b0) hi++;
                @(negedge clk);
            end
            chk(hi == 0, "R8 start bit held without ticks", hi, 0);
            baud_tick = 1'b1;
            frame_check(data_pat(9'h0A0, 8), 10, 2, "R8 frame after ticks resume");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule